// File: doc/BRIEF.md
# Four-Channel Linear-Code Sample Corrector

This block sits after a bank of four parallel linear transforms (for example four FFT cores) and three redundant copies of the same transform. Each redundant transform was fed the sum of three of the four original inputs. By linearity, each redundant output must equal the sum of the matching three original outputs. Every cycle the block takes one complex sample from each of the seven channels. It checks the three sum relations against a small tolerance and works out from the pattern of broken relations which single channel is wrong.

A wrong data channel is rebuilt algebraically. The block takes one redundant output and subtracts the two healthy data channels that share its group. The result is saturated to the data width. A wrong redundant channel is reported, but the data passes through unchanged. The four cleaned streams, a valid flag and a 3-bit fault location come out one register stage after the inputs. The model is one faulty channel at a time.

Top module: `chan_corrector`

## Requirements
- R1: `valid_o` equals `valid_i` of the previous clock. Data and location outputs are registered, so each has one cycle of latency.
- R2: A check passes when its difference lies in [-1, 1] on both the real and the imaginary part. The difference is the redundant sample minus the sum of its three data samples. When all checks pass, `err_loc_o` is 0 and no channel is altered.
- R3: A difference of magnitude 2 or more fails the check.
- R4: The real and imaginary parts are judged separately. An out-of-tolerance imaginary part alone fails the check.
- R5: There are three checks. Check A is redundant 0 against data 0+1+2. Check B is redundant 1 against data 0+1+3. Check C is redundant 2 against data 0+2+3. If A, B and C all fail, `err_loc_o`=1 and data 0 is rebuilt as red0−d1−d2. If only A and B fail, the code is 2 and d1 = red0−d0−d2. If only A and C fail, the code is 3 and d2 = red0−d0−d1. If only B and C fail, the code is 4 and d3 = red1−d0−d1.
- R6: If only A fails, `err_loc_o` is 5. If only B fails, it is 6. If only C fails, it is 7. In each of these cases all four data outputs equal their inputs.
- R7: Any data channel whose index plus one differs from `err_loc_o` is passed through unchanged.
- R8: A rebuilt value is saturated to the signed 14-bit range [-8192, 8191].
- R9: While `rst_ni` is low, `valid_o`, `err_loc_o` and all data outputs are 0.
- R10: A cycle with `valid_i` low gives `valid_o` low and `err_loc_o` 0 on the next cycle, whatever the inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input samples valid |
| d_re_i | input | 56 | Real parts of data channels; channel k at bits [14k+13:14k], signed |
| d_im_i | input | 56 | Imaginary parts of data channels, same layout |
| r_re_i | input | 48 | Real parts of redundant channels; channel j at bits [16j+15:16j], signed |
| r_im_i | input | 48 | Imaginary parts of redundant channels, same layout |
| valid_o | output | 1 | Output samples valid |
| y_re_o | output | 56 | Corrected real parts, layout as d_re_i |
| y_im_o | output | 56 | Corrected imaginary parts, layout as d_im_i |
| err_loc_o | output | 3 | 0 none, 1..4 data channel, 5..7 redundant channel |

## Verification
Rebuilding a faulty data channel and saturating the result can happen in the same cycle. This occurs when the redundant sample used for the rebuild is far from the sum of the healthy channels. The bench provokes it by driving a near-full-scale redundant value while breaking all three checks. It then expects location 1 together with a clipped positive or negative data-0 output, while the untouched channels still pass through. Tolerance-edge deltas of 1 and 2 on one data channel separate a passing check from a failing one within the same stream.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
  typedef enum logic [2:0] {
    LOC_NONE = 3'd0,
    LOC_D0   = 3'd1,
    LOC_D1   = 3'd2,
    LOC_D2   = 3'd3,
    LOC_D3   = 3'd4,
    LOC_R0   = 3'd5,
    LOC_R1   = 3'd6,
    LOC_R2   = 3'd7
  } loc_e;

  localparam int unsigned NUM_DATA = 4;
  localparam int unsigned NUM_RED  = 3;
endpackage

// File: rtl/lcc_check.sv
module lcc_check #(
  parameter int unsigned DW  = 14,
  parameter int unsigned RW  = 16,
  parameter int unsigned TOL = 1,
  localparam int unsigned EW = RW + 2
) (
  input  logic signed [RW-1:0] ref_re_i,
  input  logic signed [RW-1:0] ref_im_i,
  input  logic signed [DW-1:0] a_re_i,
  input  logic signed [DW-1:0] a_im_i,
  input  logic signed [DW-1:0] b_re_i,
  input  logic signed [DW-1:0] b_im_i,
  input  logic signed [DW-1:0] c_re_i,
  input  logic signed [DW-1:0] c_im_i,
  output logic                 fail_o
);
  localparam logic signed [EW-1:0] TOL_P = EW'(TOL);
  localparam logic signed [EW-1:0] TOL_N = -TOL_P;

  logic signed [EW-1:0] diff_re, diff_im;
  logic signed [EW-1:0] r_re_x, r_im_x, a_re_x, a_im_x, b_re_x, b_im_x, c_re_x, c_im_x;

  always_comb begin
    r_re_x = ref_re_i; r_im_x = ref_im_i;
    a_re_x = a_re_i;   a_im_x = a_im_i;
    b_re_x = b_re_i;   b_im_x = b_im_i;
    c_re_x = c_re_i;   c_im_x = c_im_i;
    diff_re = r_re_x - a_re_x - b_re_x - c_re_x;
    diff_im = r_im_x - a_im_x - b_im_x - c_im_x;
    fail_o  = (diff_re > TOL_P) || (diff_re < TOL_N) ||
              (diff_im > TOL_P) || (diff_im < TOL_N);
  end
endmodule

// File: rtl/lcc_syndrome.sv
module lcc_syndrome
  import lcc_pkg::*;
(
  input  logic [2:0] fail_i,  // {C, B, A}
  output loc_e       loc_o
);
  always_comb begin
    unique case (fail_i)
      3'b111:  loc_o = LOC_D0;
      3'b011:  loc_o = LOC_D1;
      3'b101:  loc_o = LOC_D2;
      3'b110:  loc_o = LOC_D3;
      3'b001:  loc_o = LOC_R0;
      3'b010:  loc_o = LOC_R1;
      3'b100:  loc_o = LOC_R2;
      default: loc_o = LOC_NONE;
    endcase
  end
endmodule

// File: rtl/lcc_rebuild.sv
module lcc_rebuild #(
  parameter int unsigned DW = 14,
  parameter int unsigned RW = 16,
  localparam int unsigned EW = RW + 2
) (
  input  logic signed [RW-1:0] ref_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  output logic signed [DW-1:0] val_o
);
  localparam logic signed [EW-1:0] MAX_V = EW'((1 << (DW - 1)) - 1);
  localparam logic signed [EW-1:0] MIN_V = -MAX_V - EW'(1);

  logic signed [EW-1:0] r_x, a_x, b_x, raw;

  always_comb begin
    r_x = ref_i;
    a_x = a_i;
    b_x = b_i;
    raw = r_x - a_x - b_x;
    if (raw > MAX_V)      val_o = MAX_V[DW-1:0];
    else if (raw < MIN_V) val_o = MIN_V[DW-1:0];
    else                  val_o = raw[DW-1:0];
  end
endmodule

// File: rtl/chan_corrector.sv
module chan_corrector
  import lcc_pkg::*;
#(
  parameter int unsigned DW  = 14,
  parameter int unsigned RW  = 16,
  parameter int unsigned TOL = 1,
  localparam int unsigned ND = NUM_DATA,
  localparam int unsigned NR = NUM_RED
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [ND*DW-1:0] d_re_i,
  input  logic [ND*DW-1:0] d_im_i,
  input  logic [NR*RW-1:0] r_re_i,
  input  logic [NR*RW-1:0] r_im_i,
  output logic             valid_o,
  output logic [ND*DW-1:0] y_re_o,
  output logic [ND*DW-1:0] y_im_o,
  output logic [2:0]       err_loc_o
);
  logic signed [DW-1:0] d_re [ND];
  logic signed [DW-1:0] d_im [ND];
  logic signed [RW-1:0] r_re [NR];
  logic signed [RW-1:0] r_im [NR];
  logic signed [DW-1:0] rb_re [ND];
  logic signed [DW-1:0] rb_im [ND];
  logic [NR-1:0]        fail;
  loc_e                 loc;
  logic [ND*DW-1:0]     y_re_nxt, y_im_nxt;

  for (genvar k = 0; k < ND; k++) begin : g_dunpack
    assign d_re[k] = d_re_i[k*DW +: DW];
    assign d_im[k] = d_im_i[k*DW +: DW];
  end
  for (genvar j = 0; j < NR; j++) begin : g_runpack
    assign r_re[j] = r_re_i[j*RW +: RW];
    assign r_im[j] = r_im_i[j*RW +: RW];
  end

  // check j: red j vs d0 + d(b) + d(c); groups {0,1,2} {0,1,3} {0,2,3}
  for (genvar j = 0; j < NR; j++) begin : g_chk
    localparam int unsigned IB = (j == 2) ? 2 : 1;
    localparam int unsigned IC = (j == 0) ? 2 : 3;
    lcc_check #(.DW(DW), .RW(RW), .TOL(TOL)) u_check (
      .ref_re_i (r_re[j]),
      .ref_im_i (r_im[j]),
      .a_re_i   (d_re[0]),
      .a_im_i   (d_im[0]),
      .b_re_i   (d_re[IB]),
      .b_im_i   (d_im[IB]),
      .c_re_i   (d_re[IC]),
      .c_im_i   (d_im[IC]),
      .fail_o   (fail[j])
    );
  end

  lcc_syndrome u_syn (
    .fail_i (fail),
    .loc_o  (loc)
  );

  // rebuild k from red RI minus the other two members of its group
  for (genvar k = 0; k < ND; k++) begin : g_rb
    localparam int unsigned RI = (k == 3) ? 1 : 0;
    localparam int unsigned OA = (k == 0) ? 1 : 0;
    localparam int unsigned OB = (k >= 2) ? 1 : 2;
    lcc_rebuild #(.DW(DW), .RW(RW)) u_rb_re (
      .ref_i (r_re[RI]),
      .a_i   (d_re[OA]),
      .b_i   (d_re[OB]),
      .val_o (rb_re[k])
    );
    lcc_rebuild #(.DW(DW), .RW(RW)) u_rb_im (
      .ref_i (r_im[RI]),
      .a_i   (d_im[OA]),
      .b_i   (d_im[OB]),
      .val_o (rb_im[k])
    );
    always_comb begin
      if (loc == loc_e'(k + 1)) begin
        y_re_nxt[k*DW +: DW] = rb_re[k];
        y_im_nxt[k*DW +: DW] = rb_im[k];
      end else begin
        y_re_nxt[k*DW +: DW] = d_re[k];
        y_im_nxt[k*DW +: DW] = d_im[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      y_re_o    <= '0;
      y_im_o    <= '0;
      err_loc_o <= LOC_NONE;
    end else begin
      valid_o   <= valid_i;
      y_re_o    <= y_re_nxt;
      y_im_o    <= y_im_nxt;
      err_loc_o <= valid_i ? loc : LOC_NONE;
    end
  end
endmodule

// File: rtl/lcc_checker.sv
module lcc_checker #(
  parameter int unsigned DW = 14
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [4*DW-1:0] d_re_i,
  input logic [4*DW-1:0] d_im_i,
  input logic            valid_o,
  input logic [4*DW-1:0] y_re_o,
  input logic [4*DW-1:0] y_im_o,
  input logic [2:0]      err_loc_o
);
  a_r1_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o) else $error("R1 valid_o not raised");

  a_r10_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && err_loc_o == 3'd0)) else $error("R10 idle output");

  a_r10_loc_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> err_loc_o == 3'd0) else $error("R10 location while idle");

  for (genvar k = 0; k < 4; k++) begin : g_pt
    a_r7_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && err_loc_o != 3'(k + 1)) |->
        (y_re_o[k*DW +: DW] == $past(d_re_i[k*DW +: DW]) &&
         y_im_o[k*DW +: DW] == $past(d_im_i[k*DW +: DW])))
      else $error("R7 channel altered");
  end
endmodule

bind chan_corrector lcc_checker #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .d_re_i    (d_re_i),
  .d_im_i    (d_im_i),
  .valid_o   (valid_o),
  .y_re_o    (y_re_o),
  .y_im_o    (y_im_o),
  .err_loc_o (err_loc_o)
);

// File: tb/chan_corrector_tb.sv
`timescale 1ns/1ps
module chan_corrector_tb;
  localparam int DW = 14;
  localparam int RW = 16;

  typedef struct packed {
    logic signed [DW-1:0] d0, d1, d2, d3;
    logic [2:0]           fch;   // 0 none, 1..4 data, 5..7 redundant
    logic signed [15:0]   dre;
    logic signed [15:0]   dim;
    logic [2:0]           eloc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{14'sd100,   14'sd200,   -14'sd300,  14'sd400,   3'd0, 16'sd0,     16'sd0,   3'd0},
    '{14'sd1000,  -14'sd2000, 14'sd3000,  -14'sd4000, 3'd1, 16'sd500,   16'sd0,   3'd1},
    '{-14'sd50,   14'sd60,    14'sd70,    -14'sd80,   3'd2, 16'sd0,     -16'sd77, 3'd2},
    '{14'sd8000,  -14'sd8000, 14'sd123,   14'sd5,     3'd3, 16'sd3,     16'sd3,   3'd3},
    '{14'sd7,     14'sd11,    14'sd13,    14'sd2000,  3'd4, -16'sd1000, 16'sd0,   3'd4},
    '{14'sd500,   14'sd600,   14'sd700,   14'sd800,   3'd5, 16'sd50,    16'sd0,   3'd5},
    '{-14'sd500,  14'sd600,   -14'sd700,  14'sd800,   3'd6, 16'sd0,     16'sd9,   3'd6},
    '{14'sd1,     14'sd2,     14'sd3,     14'sd4,     3'd7, -16'sd2,    16'sd0,   3'd7},
    '{14'sd321,   14'sd654,   14'sd987,   -14'sd111,  3'd1, 16'sd1,     16'sd0,   3'd0},
    '{14'sd42,    -14'sd42,   14'sd84,    -14'sd84,   3'd4, 16'sd0,     -16'sd1,  3'd0},
    '{14'sd900,   14'sd800,   14'sd700,   14'sd600,   3'd2, 16'sd2,     16'sd0,   3'd2},
    '{-14'sd900,  -14'sd800,  -14'sd700,  -14'sd600,  3'd3, 16'sd0,     -16'sd2,  3'd3}
  };

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [4*DW-1:0] d_re_i = '0, d_im_i = '0;
  logic [3*RW-1:0] r_re_i = '0, r_im_i = '0;
  logic            valid_o;
  logic [4*DW-1:0] y_re_o, y_im_o;
  logic [2:0]      err_loc_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int c_re [4], c_im [4];   // clean data
  int v_re [4], v_im [4];   // driven data
  int q_re [3], q_im [3];   // driven redundant

  always #10 clk = ~clk;

  chan_corrector u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .d_re_i(d_re_i), .d_im_i(d_im_i), .r_re_i(r_re_i), .r_im_i(r_im_i),
    .valid_o(valid_o), .y_re_o(y_re_o), .y_im_o(y_im_o), .err_loc_o(err_loc_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int out_re(input int k);
    return int'($signed(y_re_o[k*DW +: DW]));
  endfunction
  function automatic int out_im(input int k);
    return int'($signed(y_im_o[k*DW +: DW]));
  endfunction

  task automatic clean_red();
    q_re[0] = c_re[0] + c_re[1] + c_re[2]; q_im[0] = c_im[0] + c_im[1] + c_im[2];
    q_re[1] = c_re[0] + c_re[1] + c_re[3]; q_im[1] = c_im[0] + c_im[1] + c_im[3];
    q_re[2] = c_re[0] + c_re[2] + c_re[3]; q_im[2] = c_im[0] + c_im[2] + c_im[3];
  endtask

  task automatic drive(input bit v);
    @(negedge clk);
    valid_i = v;
    for (int k = 0; k < 4; k++) begin
      d_re_i[k*DW +: DW] = DW'(v_re[k]);
      d_im_i[k*DW +: DW] = DW'(v_im[k]);
    end
    for (int j = 0; j < 3; j++) begin
      r_re_i[j*RW +: RW] = RW'(q_re[j]);
      r_im_i[j*RW +: RW] = RW'(q_im[j]);
    end
    @(posedge clk);
    #2;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    #35;
    chk("R9 valid_o", int'(valid_o), 0);
    chk("R9 err_loc_o", int'(err_loc_o), 0);
    chk("R9 y_re_o", int'(y_re_o != '0), 0);
    chk("R9 y_im_o", int'(y_im_o != '0), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int n = 0; n < NV; n++) begin
      c_re[0] = TBL[n].d0; c_re[1] = TBL[n].d1; c_re[2] = TBL[n].d2; c_re[3] = TBL[n].d3;
      for (int k = 0; k < 4; k++) begin
        c_im[k] = -(c_re[k] / 2) + 3 * k;
        v_re[k] = c_re[k];
        v_im[k] = c_im[k];
      end
      clean_red();
      if (TBL[n].fch >= 1 && TBL[n].fch <= 4) begin
        v_re[TBL[n].fch - 1] += int'(TBL[n].dre);
        v_im[TBL[n].fch - 1] += int'(TBL[n].dim);
      end else if (TBL[n].fch >= 5) begin
        q_re[TBL[n].fch - 5] += int'(TBL[n].dre);
        q_im[TBL[n].fch - 5] += int'(TBL[n].dim);
      end
      drive(1'b1);
      // R1 latency, R2/R3/R4 tolerance, R5/R6 decode
      chk("R1 valid_o", int'(valid_o), 1);
      chk("R5 R6 R2 R3 R4 err_loc_o", int'(err_loc_o), int'(TBL[n].eloc));
      for (int k = 0; k < 4; k++) begin
        if (int'(TBL[n].eloc) == k + 1) begin
          chk("R5 rebuilt re", out_re(k), c_re[k]);
          chk("R5 rebuilt im", out_im(k), c_im[k]);
        end else begin
          chk("R7 R6 pass re", out_re(k), v_re[k]);
          chk("R7 R6 pass im", out_im(k), v_im[k]);
        end
      end
    end

    // R10: invalid cycle with a faulty pattern
    for (int k = 0; k < 4; k++) begin
      c_re[k] = 10 * k; c_im[k] = -k; v_re[k] = c_re[k]; v_im[k] = c_im[k];
    end
    clean_red();
    q_re[0] += 100;
    drive(1'b0);
    chk("R10 valid_o", int'(valid_o), 0);
    chk("R10 err_loc_o", int'(err_loc_o), 0);

    // R8: rebuild of data 0 with positive saturation
    for (int k = 0; k < 4; k++) begin
      c_re[k] = 100 + k; c_im[k] = k; v_re[k] = c_re[k]; v_im[k] = c_im[k];
    end
    clean_red();
    q_re[0] = 32000; q_re[1] += 100; q_re[2] += 100;
    drive(1'b1);
    chk("R8 loc", int'(err_loc_o), 1);
    chk("R8 sat high", out_re(0), 8191);
    chk("R8 im rebuilt", out_im(0), c_im[0]);
    chk("R8 R7 pass d1", out_re(1), v_re[1]);

    // R8: negative saturation
    clean_red();
    q_re[0] = -32000; q_re[1] -= 100; q_re[2] -= 100;
    drive(1'b1);
    chk("R8 loc neg", int'(err_loc_o), 1);
    chk("R8 sat low", out_re(0), -8192);
    chk("R8 R7 pass d3", out_re(3), v_re[3]);

    drive(1'b0);
    chk("R10 valid_o tail", int'(valid_o), 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule